// File: doc/BRIEF.md
# Iterative AES-128 Cipher and Inverse Cipher Core

This block runs AES-128 in either direction through one shared round datapath that is reused every clock. A one-cycle `start_i` pulse loads a 128-bit block, a 128-bit key and a direction bit. The block is mixed with the key on that same edge. After that, one full round completes per clock. The round key that the next round needs is derived from the 128-bit key register in the same cycle, so no expanded schedule is ever stored.

For the inverse direction, the core uses the equivalent inverse cipher. The key supplied with `start_i` must be the last round key of the forward schedule. Each cycle the key register steps backwards through the schedule. Every key except the first one and the last one passes through the inverse column mix before it is added to the state. The result is registered and flagged by a single-cycle `done_o` pulse. It stays on `result_o` until the next block completes.

Bytes are numbered from the most significant end: byte 0 is bits [127:120], and byte n is bits [127-8n -: 8]. Byte n sits in column n/4 and row n%4 of the state.

Top module: `aes_iter_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears: `done_o` is 0 and `result_o` is all zeros after that edge.
- R2: With `decrypt_i` = 0 at the start edge, the result is the AES-128 encryption of `block_i` under `key_i`. Key 000102030405060708090a0b0c0d0e0f and block 00112233445566778899aabbccddeeff give 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: With `decrypt_i` = 1 at the start edge, `key_i` is taken as the tenth round key of the forward schedule, and the result is the AES-128 decryption of `block_i`. Key 13111d7fe3944a17f307a78b4d2b30c5 and block 69c4e0d86a7b0430d8cdb78070b4c55a give 00112233445566778899aabbccddeeff.
- R4: If `start_i` is sampled high at rising edge k while the core is idle, `done_o` and the new `result_o` appear after edge k+10. That is the eleventh edge, counting edge k as the first.
- R5: `done_o` is high for exactly one cycle per accepted block and is low at all other times.
- R6: A `start_i` sampled while a block is in progress has no effect. The running block's result and timing do not change, and no extra completion follows.
- R7: `result_o` changes only on the edge that raises `done_o`, and holds its value until the next completion.
- R8: A start sampled on the edge right after the one that raised `done_o` is accepted, so a held `start_i` yields one block every 11 cycles.
- R9: The direction, block and key are captured at the start edge. Changing `decrypt_i`, `block_i` or `key_i` during a block does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a block when idle |
| decrypt_i | input | 1 | 0 = encrypt, 1 = decrypt, sampled with start |
| block_i | input | 128 | Input data block, byte 0 in bits [127:120] |
| key_i | input | 128 | Cipher key (encrypt) or last round key (decrypt) |
| result_o | output | 128 | Registered output block |
| done_o | output | 1 | One-cycle pulse when `result_o` is new |

## Verification
A result is due exactly ten edges after the edge that accepts its start. The bench models this with an edge counter. At every rising edge, its behavioural model records whether the core would accept a start, computes the full cipher result with its own table-driven AES, and stores the edge at which that result is due. On every falling edge, the bench compares `done_o` and `result_o` with what the model predicts for the edge just passed: a pulse and the new value only on the due edge, otherwise no pulse and the previous value. Starts issued mid-block, starts held high through completions, and input changes during a block therefore show up as cycle-exact mismatches.

// File: rtl/aes_iter_pkg.sv
`timescale 1ns/1ps
package aes_iter_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_ROWS   = 4;
  localparam int NUM_WORDS  = 4;
  localparam int WORD_W     = NUM_ROWS * BYTE_W;
  localparam int BLOCK_W    = NUM_WORDS * WORD_W;
  localparam int NUM_BYTES  = BLOCK_W / BYTE_W;
  localparam int NUM_ROUNDS = 10;
  localparam logic [BYTE_W-1:0] FIELD_POLY = 8'h1b;
  localparam logic [BYTE_W-1:0] INV_EXP    = 8'hfe;
  localparam logic [BYTE_W-1:0] FWD_CONST  = 8'h63;
  localparam logic [BYTE_W-1:0] REV_CONST  = 8'h05;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [BLOCK_W-1:0] block_t;

  function automatic byte_t xt(byte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_POLY : '0);
  endfunction

  function automatic byte_t gmul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xt(x);
    end
    return acc;
  endfunction

  // a^254 is the field inverse, and 0 maps to 0
  function automatic byte_t ginv(byte_t a);
    byte_t acc = 8'h01;
    byte_t sq  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (INV_EXP[i]) acc = gmul(acc, sq);
      sq = gmul(sq, sq);
    end
    return acc;
  endfunction

  function automatic byte_t affine_fwd(byte_t b);
    byte_t o;
    for (int i = 0; i < BYTE_W; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    return o ^ FWD_CONST;
  endfunction

  function automatic byte_t affine_rev(byte_t b);
    byte_t o;
    for (int i = 0; i < BYTE_W; i++)
      o[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8];
    return o ^ REV_CONST;
  endfunction

  function automatic byte_t sub_byte(byte_t b, logic inv);
    return inv ? ginv(affine_rev(b)) : affine_fwd(ginv(b));
  endfunction

  function automatic word_t sub_word(word_t w);
    word_t o;
    for (int i = 0; i < NUM_ROWS; i++)
      o[WORD_W-1-BYTE_W*i -: BYTE_W] = sub_byte(w[WORD_W-1-BYTE_W*i -: BYTE_W], 1'b0);
    return o;
  endfunction

  function automatic word_t rot_word(word_t w);
    return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1 -: BYTE_W]};
  endfunction

  // round constant: 01 doubled idx times in the field
  function automatic byte_t rcon(int idx);
    byte_t r = 8'h01;
    for (int i = 0; i < NUM_ROUNDS; i++)
      if (i < idx) r = xt(r);
    return r;
  endfunction
endpackage

// File: rtl/aes_mixcol.sv
`timescale 1ns/1ps
module aes_mixcol
  import aes_iter_pkg::*;
(
  input  logic  inv_i,
  input  word_t col_i,
  output word_t col_o
);
  byte_t a0, a1, a2, a3, sum, sum8, y, z;

  assign a0 = col_i[WORD_W-1          -: BYTE_W];
  assign a1 = col_i[WORD_W-1-BYTE_W   -: BYTE_W];
  assign a2 = col_i[WORD_W-1-2*BYTE_W -: BYTE_W];
  assign a3 = col_i[WORD_W-1-3*BYTE_W -: BYTE_W];

  // Shared core: the inverse needs only extra terms on the two helpers
  assign sum  = a0 ^ a1 ^ a2 ^ a3;
  assign sum8 = xt(xt(xt(sum)));
  assign y = inv_i ? (sum ^ sum8 ^ xt(xt(a0 ^ a2))) : sum;
  assign z = inv_i ? (sum ^ sum8 ^ xt(xt(a1 ^ a3))) : sum;

  assign col_o = {a0 ^ y ^ xt(a0 ^ a1),
                  a1 ^ z ^ xt(a1 ^ a2),
                  a2 ^ y ^ xt(a2 ^ a3),
                  a3 ^ z ^ xt(a3 ^ a0)};
endmodule

// File: rtl/aes_round.sv
`timescale 1ns/1ps
module aes_round
  import aes_iter_pkg::*;
(
  input  block_t state_i,
  input  block_t rkey_i,
  input  logic   inv_i,
  input  logic   last_i,
  output block_t state_o
);
  byte_t  subbed [NUM_BYTES];
  block_t shifted, mixed;

  genvar g;
  generate
    for (g = 0; g < NUM_BYTES; g++) begin : g_sub
      assign subbed[g] = sub_byte(state_i[BLOCK_W-1-BYTE_W*g -: BYTE_W], inv_i);
    end
  endgenerate

  // row r rotates left by r columns forward, right by r columns inverse
  always_comb begin
    shifted = '0;
    for (int idx = 0; idx < NUM_BYTES; idx++) begin
      int r;
      int c;
      int sc;
      r  = idx % NUM_ROWS;
      c  = idx / NUM_ROWS;
      sc = inv_i ? (c - r + NUM_WORDS) % NUM_WORDS : (c + r) % NUM_WORDS;
      shifted[BLOCK_W-1-BYTE_W*idx -: BYTE_W] = subbed[NUM_ROWS*sc + r];
    end
  end

  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_mix
      aes_mixcol u_mix (
        .inv_i (inv_i),
        .col_i (shifted[BLOCK_W-1-WORD_W*g -: WORD_W]),
        .col_o (mixed[BLOCK_W-1-WORD_W*g -: WORD_W])
      );
    end
  endgenerate

  assign state_o = (last_i ? shifted : mixed) ^ rkey_i;
endmodule

// File: rtl/aes_key_step.sv
`timescale 1ns/1ps
module aes_key_step
  import aes_iter_pkg::*;
#(
  parameter int IDX_W = 4
)(
  input  block_t           key_i,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] rc_idx_i,
  output block_t           key_o
);
  word_t w0, w1, w2, w3, back3, sw_in, t, n0, n1, n2;

  assign w0 = key_i[BLOCK_W-1          -: WORD_W];
  assign w1 = key_i[BLOCK_W-1-WORD_W   -: WORD_W];
  assign w2 = key_i[BLOCK_W-1-2*WORD_W -: WORD_W];
  assign w3 = key_i[BLOCK_W-1-3*WORD_W -: WORD_W];

  // One substitution path serves both directions
  assign back3 = w3 ^ w2;
  assign sw_in = inv_i ? back3 : w3;
  assign t     = sub_word(rot_word(sw_in)) ^ {rcon(int'(rc_idx_i)), {(WORD_W-BYTE_W){1'b0}}};

  assign n0 = w0 ^ t;
  assign n1 = n0 ^ w1;
  assign n2 = n1 ^ w2;

  assign key_o = inv_i ? {w0 ^ t, w1 ^ w0, w2 ^ w1, back3}
                       : {n0, n1, n2, n2 ^ w3};
endmodule

// File: rtl/aes_iter_core.sv
`timescale 1ns/1ps
module aes_iter_core
  import aes_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               decrypt_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  logic [BLOCK_W-1:0] key_i,
  output logic [BLOCK_W-1:0] result_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(NUM_ROUNDS + 1);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NUM_ROUNDS);

  logic             busy_q, mode_q, mode_src, last_rnd;
  logic [CNT_W-1:0] rnd_q, rc_idx;
  block_t           state_q, key_q, key_src, key_nxt, key_imc, rkey, round_out;

  assign last_rnd = (rnd_q == LAST_RND);
  assign key_src  = busy_q ? key_q  : key_i;
  assign mode_src = busy_q ? mode_q : decrypt_i;

  // forward: key r+1 uses constant index r; reverse: key r-1 uses index r-1
  always_comb begin
    if (!mode_src)
      rc_idx = busy_q ? rnd_q : '0;
    else if (!busy_q)
      rc_idx = LAST_RND - CNT_W'(1);
    else if (rnd_q >= LAST_RND)
      rc_idx = '0;
    else
      rc_idx = LAST_RND - CNT_W'(1) - rnd_q;
  end

  aes_key_step #(.IDX_W(CNT_W)) u_key_step (
    .key_i    (key_src),
    .inv_i    (mode_src),
    .rc_idx_i (rc_idx),
    .key_o    (key_nxt)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_key_imc
      aes_mixcol u_kmix (
        .inv_i (1'b1),
        .col_i (key_q[BLOCK_W-1-WORD_W*g -: WORD_W]),
        .col_o (key_imc[BLOCK_W-1-WORD_W*g -: WORD_W])
      );
    end
  endgenerate

  // inverse rounds 1..9 need the column-mixed key, the final round the raw key
  assign rkey = (mode_q && !last_rnd) ? key_imc : key_q;

  aes_round u_round (
    .state_i (state_q),
    .rkey_i  (rkey),
    .inv_i   (mode_q),
    .last_i  (last_rnd),
    .state_o (round_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      mode_q   <= 1'b0;
      rnd_q    <= '0;
      state_q  <= '0;
      key_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          mode_q  <= decrypt_i;
          rnd_q   <= CNT_W'(1);
          state_q <= block_i ^ key_i;
          key_q   <= key_nxt;
        end
      end else begin
        state_q <= round_out;
        key_q   <= key_nxt;
        if (last_rnd) begin
          busy_q   <= 1'b0;
          result_o <= round_out;
          done_o   <= 1'b1;
        end else begin
          rnd_q <= rnd_q + CNT_W'(1);
        end
      end
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> (busy_q && rnd_q == CNT_W'(1))); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_q && $past(busy_q) && $past(last_rnd))); // R4

  AST_RND_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (rnd_q >= CNT_W'(1) && rnd_q <= LAST_RND)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_rnd) |=> (busy_q && rnd_q == $past(rnd_q) + CNT_W'(1))); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!done_o && $past(!rst)) |-> $stable(result_o)); // R7

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_rnd) |=> $stable(mode_q)); // R9
endmodule

// File: tb/test_aes_iter_core.sv
`timescale 1ns/1ps
module test_aes_iter_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] block_i = '0;
  logic [127:0] key_i = '0;
  logic [127:0] result_o;
  logic         done_o;

  always #2 clk = ~clk;

  aes_iter_core i_aes_iter_core (
    .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
    .block_i(block_i), .key_i(key_i), .result_o(result_o), .done_o(done_o)
  );

  localparam logic [127:0] FIPS_KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FIPS_PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FIPS_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string phase_tag = "";

  logic [7:0] sb [256];
  logic [7:0] isb [256];

  // ---------------- behavioural reference ----------------
  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] gb(logic [127:0] s, int i);
    return s[127-8*i -: 8];
  endfunction

  function automatic logic [127:0] f_sub(logic [127:0] s, bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = inv ? isb[gb(s, i)] : sb[gb(s, i)];
    return o;
  endfunction

  function automatic logic [127:0] f_shift(logic [127:0] s, bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = gb(s, r + 4*((inv ? c + 4 - r : c + r) % 4));
    return o;
  endfunction

  function automatic logic [127:0] f_mix(logic [127:0] s, bit inv);
    logic [127:0] o;
    logic [7:0] cf [4];
    if (inv) cf = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     cf = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 0;
        for (int j = 0; j < 4; j++) acc ^= gm(cf[(j - r + 4) % 4], gb(s, 4*c + j));
        o[127-8*(4*c+r) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [31:0] g_word(logic [31:0] w, logic [7:0] rc);
    logic [31:0] t = {w[23:0], w[31:24]};
    return {sb[t[31:24]] ^ rc, sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
  endfunction

  function automatic logic [10:0][127:0] expand(logic [127:0] k);
    logic [10:0][127:0] ks;
    logic [7:0] rc = 8'h01;
    ks[0] = k;
    for (int i = 1; i <= 10; i++) begin
      logic [31:0] w [4];
      for (int j = 0; j < 4; j++) w[j] = ks[i-1][127-32*j -: 32];
      w[0] ^= g_word(w[3], rc);
      for (int j = 1; j < 4; j++) w[j] ^= w[j-1];
      ks[i] = {w[0], w[1], w[2], w[3]};
      rc = gm(rc, 8'h02);
    end
    return ks;
  endfunction

  function automatic logic [127:0] unexpand(logic [127:0] k10);
    logic [7:0] rcs [11];
    logic [127:0] cur = k10;
    rcs[1] = 8'h01;
    for (int i = 2; i <= 10; i++) rcs[i] = gm(rcs[i-1], 8'h02);
    for (int i = 10; i >= 1; i--) begin
      logic [31:0] w [4];
      for (int j = 0; j < 4; j++) w[j] = cur[127-32*j -: 32];
      for (int j = 3; j >= 1; j--) w[j] ^= w[j-1];
      w[0] ^= g_word(w[3], rcs[i]);
      cur = {w[0], w[1], w[2], w[3]};
    end
    return cur;
  endfunction

  function automatic logic [127:0] ref_enc(logic [127:0] pt, logic [127:0] k);
    logic [10:0][127:0] ks = expand(k);
    logic [127:0] s = pt ^ ks[0];
    for (int r = 1; r <= 10; r++) begin
      s = f_shift(f_sub(s, 0), 0);
      if (r < 10) s = f_mix(s, 0);
      s ^= ks[r];
    end
    return s;
  endfunction

  function automatic logic [127:0] ref_dec(logic [127:0] ct, logic [127:0] k10);
    logic [10:0][127:0] ks = expand(unexpand(k10));
    logic [127:0] s = ct ^ ks[10];
    for (int r = 9; r >= 0; r--) begin
      s = f_sub(f_shift(s, 1), 1) ^ ks[r];
      if (r > 0) s = f_mix(s, 1);
    end
    return s;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- cycle model ----------------
  int ecnt = 0;
  int due = 0;
  bit pend = 0;
  bit m_rst = 1;
  bit exp_dec = 0;
  logic [127:0] exp_res = '0;
  logic [127:0] last_res = '0;

  always @(posedge clk) begin
    ecnt++;
    m_rst = rst;
    if (rst) begin
      pend = 0;
      last_res = '0;
    end else if (start_i && (!pend || ecnt > due)) begin
      exp_dec = decrypt_i;
      exp_res = decrypt_i ? ref_dec(block_i, key_i) : ref_enc(block_i, key_i);
      due  = ecnt + 10;
      pend = 1;
    end
  end

  always @(negedge clk) begin
    if (ecnt >= 1 && !finished) begin
      if (m_rst) begin
        chk(done_o == 1'b0, "R1 done", {127'd0, done_o}, '0);
        chk(result_o == '0, "R1 result", result_o, '0);
      end else if (pend && ecnt == due) begin
        chk(done_o == 1'b1, {"R4 done due ", phase_tag}, {127'd0, done_o}, 128'd1);
        chk(result_o == exp_res, {exp_dec ? "R3" : "R2", " result ", phase_tag}, result_o, exp_res);
        last_res = exp_res;
      end else begin
        chk(done_o == 1'b0, {"R5 no done ", phase_tag}, {127'd0, done_o}, '0);
        chk(result_o == last_res, {"R7 held ", phase_tag}, result_o, last_res);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_block(logic [127:0] blk, logic [127:0] k, bit dec);
    @(negedge clk);
    block_i = blk; key_i = k; decrypt_i = dec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int p = 1;
    int q = 1;
    logic [127:0] k10;
    sb[0] = 8'h63;
    do begin
      int x;
      p = (p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 0)) & 8'hff;
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4); q = q & 8'hff;
      if ((q & 8'h80) != 0) q = q ^ 8'h09;
      x = q;
      for (int n = 1; n <= 4; n++) x = x ^ (((q << n) | (q >> (8 - n))) & 8'hff);
      sb[p] = 8'(x ^ 8'h63);
    end while (p != 1);
    for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);

    // the model itself must reproduce the published vector (R2, R3)
    k10 = expand(FIPS_KEY)[10];
    chk(ref_enc(FIPS_PT, FIPS_KEY) == FIPS_CT, "R2 model vector", ref_enc(FIPS_PT, FIPS_KEY), FIPS_CT);
    chk(ref_dec(FIPS_CT, k10) == FIPS_PT, "R3 model vector", ref_dec(FIPS_CT, k10), FIPS_PT);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: known vector, forward; result due at the 11th negedge after driving start
    run_block(FIPS_PT, FIPS_KEY, 1'b0);
    repeat (10) @(negedge clk);
    chk(done_o && result_o == FIPS_CT, "R2 R4 known ciphertext", result_o, FIPS_CT);
    repeat (3) @(negedge clk);

    // R3: known vector, inverse with the last round key
    run_block(FIPS_CT, k10, 1'b1);
    repeat (10) @(negedge clk);
    chk(done_o && result_o == FIPS_PT, "R3 R4 known plaintext", result_o, FIPS_PT);
    repeat (3) @(negedge clk);

    // R6 R9: start pulses and input changes while busy are ignored
    phase_tag = "R6 R9";
    run_block({4{$urandom}}, {4{$urandom}}, 1'b0);
    repeat (3) @(negedge clk);
    block_i = {4{$urandom}}; key_i = {4{$urandom}}; decrypt_i = 1'b1; start_i = 1'b1;
    repeat (2) @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    decrypt_i = 1'b0; block_i = '1;
    repeat (8) @(negedge clk);

    // R8: start held high, a new block every 11 cycles with data changing each cycle
    phase_tag = "R8";
    start_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      block_i = {4{$urandom}}; key_i = {4{$urandom}}; decrypt_i = 1'($urandom);
      @(negedge clk);
    end
    start_i = 1'b0;
    repeat (14) @(negedge clk);

    // R2 R3: mixed directions, varied gaps
    phase_tag = "R2 R3 mixed";
    for (int i = 0; i < 16; i++) begin
      run_block({4{$urandom}}, {4{$urandom}}, 1'(i % 2));
      repeat (10 + ($urandom % 4)) @(negedge clk);
    end
    repeat (4) @(negedge clk);

    // R1: reset in the middle of a block clears everything
    phase_tag = "R1";
    run_block({4{$urandom}}, {4{$urandom}}, 1'b0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (14) @(negedge clk);

    finish_run();
  end

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule